// File: doc/BRIEF.md
# DMA Channel Terminal-Count Controller

This block keeps the position of one DMA channel and handles what happens when the channel runs out of data. It holds a current source address, a current destination address and a current byte count. Each of these has a reload copy, which is presented on input ports. A start strobe copies the three reload values into the current registers and enables the channel. After that, every completed transfer unit of 1, 2 or 4 bytes reduces the count by the unit size. It also moves each address forward by the unit size, or leaves it where it is, according to a per-address increment bit.

The terminal condition is the count reaching zero. On that event the block does the following:

- It sets a sticky end status bit.
- It can raise a level interrupt, gated by a channel enable and a common enable.
- It can pulse an active-low end strobe for one cycle.
- It can drop its own channel enable.
- It can reload the current source, destination and count from their reload copies. Each of the three has its own selection bit.

With these choices a channel either stops after one block or restarts at once with no gap. Bus mastering, arbitration and the data path are handled elsewhere. The adjacent engine reports each completed unit on `xfer_done` and reads the current registers.

Top module: `dma_eot_ctrl`

## Requirements
- R1: After reset the channel is disabled, all current registers are zero, the status and interrupt are low and `tc_n` is high. A `start` pulse loads all three current registers from the reload inputs and sets `chan_en` in the following cycle. `start` takes priority over `xfer_done` in the same cycle.
- R2: An accepted unit lowers `cur_cnt` by the smaller of the unit size and the remaining count, so the count never wraps below zero. The unit size is coded on `unit_sz`: 0 = 1 byte, 1 = 2 bytes, 2 or 3 = 4 bytes.
- R3: On an accepted unit, each address moves forward by the unit size when its increment bit (`src_inc`, `dst_inc`) is 1. When the bit is 0 the address does not change.
- R4: An end event occurs when an accepted unit brings the count to zero, and it sets `end_sts` in the next cycle. `end_sts` stays set until a `sts_clr` pulse clears it. If `sts_clr` and an end event fall in the same cycle, the status is set.
- R5: `irq` is high exactly when `end_sts`, `ch_ie` and `com_ie` are all 1.
- R6: When `tc_out_en` is 1, each end event drives `tc_n` low for exactly the following cycle. When `tc_out_en` is 0, `tc_n` stays high.
- R7: At an end event, `chan_en` is cleared if `cfg_eclr` is 1 and stays set if `cfg_eclr` is 0.
- R8: At an end event, each of `cfg_srld`, `cfg_drld` and `cfg_crld` independently loads its current register from its reload input. Without reload, an address takes its normal last advance and the count stays at zero.
- R9: A unit is ignored, leaving the count and both addresses unchanged, while `chan_en` is 0 or the count is zero. After a count reload with the enable kept, a unit in the very next cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Load current registers from reload inputs and enable |
| xfer_done | input | 1 | One transfer unit completed this cycle |
| unit_sz | input | 2 | Unit size code (0:1B, 1:2B, 2/3:4B) |
| src_inc | input | 1 | Source address increments per unit |
| dst_inc | input | 1 | Destination address increments per unit |
| cfg_eclr | input | 1 | Clear channel enable at end |
| cfg_srld | input | 1 | Reload source address at end |
| cfg_drld | input | 1 | Reload destination address at end |
| cfg_crld | input | 1 | Reload byte count at end |
| tc_out_en | input | 1 | Enable the end strobe |
| ch_ie | input | 1 | Channel interrupt enable |
| com_ie | input | 1 | Common interrupt enable |
| sts_clr | input | 1 | Write-1-to-clear strobe for the status |
| rld_src | input | AW | Reload source address |
| rld_dst | input | AW | Reload destination address |
| rld_cnt | input | CW | Reload byte count |
| cur_src | output | AW | Current source address |
| cur_dst | output | AW | Current destination address |
| cur_cnt | output | CW | Current byte count |
| chan_en | output | 1 | Channel transfer enable |
| end_sts | output | 1 | Sticky end status |
| irq | output | 1 | Interrupt request level |
| tc_n | output | 1 | Active-low one-cycle end strobe |

## Verification
Two collisions matter. The first is a status clear strobe arriving in the same cycle as the terminal unit. The bench drives `sts_clr` together with the final `xfer_done` and expects `end_sts` to read 1 afterwards. The second is an automatic restart, where the end event and the next accepted unit sit on back-to-back cycles. The bench holds `xfer_done` high across the reload and expects the reloaded count to drop at once and the end strobe to last a single cycle.

// File: rtl/dma_eot_pkg.sv
package dma_eot_pkg;

    typedef enum logic [1:0] {
        UNIT_1B  = 2'd0,
        UNIT_2B  = 2'd1,
        UNIT_4B  = 2'd2,
        UNIT_4BX = 2'd3
    } unit_sz_e;

    localparam int STEP_W = 3;

    function automatic logic [STEP_W-1:0] unit_bytes(input logic [1:0] sz);
        case (unit_sz_e'(sz))
            UNIT_1B:  return 3'd1;
            UNIT_2B:  return 3'd2;
            default:  return 3'd4;
        endcase
    endfunction

endpackage

// File: rtl/dma_cnt_unit.sv
module dma_cnt_unit
    import dma_eot_pkg::*;
#(
    parameter int CW = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              xfer_done,
    input  logic              chan_en,
    input  logic [STEP_W-1:0] step_bytes,
    input  logic              reload_en,
    input  logic [CW-1:0]     rld_cnt,
    output logic [CW-1:0]     cnt,
    output logic              accept,
    output logic              end_evt
);

    localparam int PAD_W = CW - STEP_W;

    typedef struct packed {
        logic [CW-1:0] cnt;
    } cnt_st_t;

    cnt_st_t       st_d, st_q;
    logic [CW-1:0] unit_w;
    logic [CW-1:0] take_w;
    logic [CW-1:0] rem_w;

    always_comb begin
        st_d   = st_q;
        unit_w = {{PAD_W{1'b0}}, step_bytes};
        take_w = (st_q.cnt < unit_w) ? st_q.cnt : unit_w;
        rem_w  = st_q.cnt - take_w;
        accept  = xfer_done && chan_en && (st_q.cnt != '0) && !start;
        end_evt = accept && (rem_w == '0);
        if (start) begin
            st_d.cnt = rld_cnt;
        end else if (end_evt) begin
            st_d.cnt = reload_en ? rld_cnt : '0;
        end else if (accept) begin
            st_d.cnt = rem_w;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign cnt = st_q.cnt;

    a_r2_no_underflow: assert property (@(posedge clk) disable iff (!rst_n)
        (accept && !end_evt) |=> (st_q.cnt < $past(st_q.cnt)) && (st_q.cnt != '0));

    a_r9_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !accept) |=> $stable(st_q.cnt));

    a_r8_cnt_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && reload_en) |=> (st_q.cnt == $past(rld_cnt)));

endmodule

// File: rtl/dma_addr_unit.sv
module dma_addr_unit
    import dma_eot_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic              accept,
    input  logic              end_evt,
    input  logic              reload_en,
    input  logic              inc_en,
    input  logic [STEP_W-1:0] step_bytes,
    input  logic [AW-1:0]     rld_addr,
    output logic [AW-1:0]     addr
);

    localparam int PAD_W = AW - STEP_W;

    typedef struct packed {
        logic [AW-1:0] addr;
    } addr_st_t;

    addr_st_t st_d, st_q;
    logic     reload_now;

    always_comb begin
        st_d       = st_q;
        reload_now = end_evt && reload_en;
        if (start || reload_now) begin
            st_d.addr = rld_addr;
        end else if (accept && inc_en) begin
            st_d.addr = st_q.addr + {{PAD_W{1'b0}}, step_bytes};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign addr = st_q.addr;

    a_r3_fixed_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !(end_evt && reload_en) && !inc_en) |=> $stable(st_q.addr));

    a_r9_no_move_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (!start && !accept) |=> $stable(st_q.addr));

endmodule

// File: rtl/dma_end_ctrl.sv
module dma_end_ctrl (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic end_evt,
    input  logic eclr,
    input  logic tc_en,
    input  logic sts_clr,
    input  logic ch_ie,
    input  logic com_ie,
    output logic chan_en,
    output logic end_sts,
    output logic irq,
    output logic tc_n
);

    typedef struct packed {
        logic en;
        logic sts;
        logic tc_n;
    } ctl_st_t;

    localparam ctl_st_t RST_ST = '{en: 1'b0, sts: 1'b0, tc_n: 1'b1};

    ctl_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.tc_n = !(end_evt && tc_en);
        if (start) begin
            st_d.en = 1'b1;
        end else if (end_evt && eclr) begin
            st_d.en = 1'b0;
        end
        if (end_evt) begin
            st_d.sts = 1'b1;
        end else if (sts_clr) begin
            st_d.sts = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= RST_ST;
        end else begin
            st_q <= st_d;
        end
    end

    assign chan_en = st_q.en;
    assign end_sts = st_q.sts;
    assign tc_n    = st_q.tc_n;
    assign irq     = st_q.sts && ch_ie && com_ie;

    a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
        end_evt |=> st_q.sts);

    a_r4_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.sts && !sts_clr) |=> st_q.sts);

    a_r6_tc_cause: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(st_q.tc_n) |-> $past(end_evt && tc_en));

    a_r7_eclr_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && eclr) |=> !st_q.en);

    a_r7_keep_en: assert property (@(posedge clk) disable iff (!rst_n)
        (end_evt && !eclr) |=> st_q.en);

endmodule

// File: rtl/dma_eot_ctrl.sv
module dma_eot_ctrl
    import dma_eot_pkg::*;
#(
    parameter int AW = 32,
    parameter int CW = 24
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          xfer_done,
    input  logic [1:0]    unit_sz,
    input  logic          src_inc,
    input  logic          dst_inc,
    input  logic          cfg_eclr,
    input  logic          cfg_srld,
    input  logic          cfg_drld,
    input  logic          cfg_crld,
    input  logic          tc_out_en,
    input  logic          ch_ie,
    input  logic          com_ie,
    input  logic          sts_clr,
    input  logic [AW-1:0] rld_src,
    input  logic [AW-1:0] rld_dst,
    input  logic [CW-1:0] rld_cnt,
    output logic [AW-1:0] cur_src,
    output logic [AW-1:0] cur_dst,
    output logic [CW-1:0] cur_cnt,
    output logic          chan_en,
    output logic          end_sts,
    output logic          irq,
    output logic          tc_n
);

    localparam int NADDR = 2;

    logic [STEP_W-1:0] step_w;
    logic              accept_w;
    logic              end_w;
    logic              en_w;
    logic [AW-1:0]     rld_a   [NADDR];
    logic [AW-1:0]     cur_a   [NADDR];
    logic              inc_a   [NADDR];
    logic              rldsel_a[NADDR];

    assign step_w      = unit_bytes(unit_sz);
    assign rld_a[0]    = rld_src;
    assign rld_a[1]    = rld_dst;
    assign inc_a[0]    = src_inc;
    assign inc_a[1]    = dst_inc;
    assign rldsel_a[0] = cfg_srld;
    assign rldsel_a[1] = cfg_drld;

    dma_cnt_unit #(.CW(CW)) u_cnt (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .xfer_done  (xfer_done),
        .chan_en    (en_w),
        .step_bytes (step_w),
        .reload_en  (cfg_crld),
        .rld_cnt    (rld_cnt),
        .cnt        (cur_cnt),
        .accept     (accept_w),
        .end_evt    (end_w)
    );

    for (genvar g = 0; g < NADDR; g++) begin : g_addr
        dma_addr_unit #(.AW(AW)) u_addr (
            .clk        (clk),
            .rst_n      (rst_n),
            .start      (start),
            .accept     (accept_w),
            .end_evt    (end_w),
            .reload_en  (rldsel_a[g]),
            .inc_en     (inc_a[g]),
            .step_bytes (step_w),
            .rld_addr   (rld_a[g]),
            .addr       (cur_a[g])
        );
    end

    assign cur_src = cur_a[0];
    assign cur_dst = cur_a[1];

    dma_end_ctrl u_end (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .end_evt (end_w),
        .eclr    (cfg_eclr),
        .tc_en   (tc_out_en),
        .sts_clr (sts_clr),
        .ch_ie   (ch_ie),
        .com_ie  (com_ie),
        .chan_en (en_w),
        .end_sts (end_sts),
        .irq     (irq),
        .tc_n    (tc_n)
    );

    assign chan_en = en_w;

    a_r9_no_accept_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!chan_en && !start && xfer_done) |=> $stable(cur_cnt) && $stable(cur_src) && $stable(cur_dst));

    a_r1_start_load: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> chan_en && (cur_cnt == $past(rld_cnt)) && (cur_src == $past(rld_src)));

endmodule

// File: tb/dma_eot_ctrl_test.sv
module dma_eot_ctrl_test;

    localparam int AW = 32;
    localparam int CW = 24;

    logic          clk = 1'b0;
    logic          rst_n;
    logic          start, xfer_done, src_inc, dst_inc;
    logic [1:0]    unit_sz;
    logic          cfg_eclr, cfg_srld, cfg_drld, cfg_crld;
    logic          tc_out_en, ch_ie, com_ie, sts_clr;
    logic [AW-1:0] rld_src, rld_dst;
    logic [CW-1:0] rld_cnt;
    logic [AW-1:0] cur_src, cur_dst;
    logic [CW-1:0] cur_cnt;
    logic          chan_en, end_sts, irq, tc_n;

    int n_chk  = 0;
    int n_fail = 0;

    always #2 clk = ~clk;

    dma_eot_ctrl #(.AW(AW), .CW(CW)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .xfer_done(xfer_done),
        .unit_sz(unit_sz), .src_inc(src_inc), .dst_inc(dst_inc),
        .cfg_eclr(cfg_eclr), .cfg_srld(cfg_srld), .cfg_drld(cfg_drld),
        .cfg_crld(cfg_crld), .tc_out_en(tc_out_en), .ch_ie(ch_ie),
        .com_ie(com_ie), .sts_clr(sts_clr), .rld_src(rld_src),
        .rld_dst(rld_dst), .rld_cnt(rld_cnt), .cur_src(cur_src),
        .cur_dst(cur_dst), .cur_cnt(cur_cnt), .chan_en(chan_en),
        .end_sts(end_sts), .irq(irq), .tc_n(tc_n)
    );

    task automatic chk(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic do_start(input logic [AW-1:0] s, input logic [AW-1:0] d,
                            input logic [CW-1:0] c);
        rld_src = s; rld_dst = d; rld_cnt = c;
        start = 1'b1;
        tick();
        start = 1'b0;
    endtask

    task automatic unit(input logic [1:0] sz);
        unit_sz = sz; xfer_done = 1'b1;
        tick();
        xfer_done = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "en", chan_en, 0);
        chk("R1", "cnt", cur_cnt, 0);
        chk("R1", "src", cur_src, 0);
        chk("R1", "sts", end_sts, 0);
        chk("R1", "irq", irq, 0);
        chk("R1", "tc_n", tc_n, 1);
    endtask

    task automatic t_start_step();
        do_start(32'h1000, 32'h2000, 24'd10);
        chk("R1", "src", cur_src, 32'h1000);
        chk("R1", "dst", cur_dst, 32'h2000);
        chk("R1", "cnt", cur_cnt, 10);
        chk("R1", "en", chan_en, 1);
        src_inc = 1'b1; dst_inc = 1'b0;
        unit(2'd2);
        chk("R2", "cnt 4B", cur_cnt, 6);
        chk("R3", "src +4", cur_src, 32'h1004);
        chk("R3", "dst fixed", cur_dst, 32'h2000);
        dst_inc = 1'b1;
        unit(2'd1);
        chk("R2", "cnt 2B", cur_cnt, 4);
        chk("R3", "src +2", cur_src, 32'h1006);
        chk("R3", "dst +2", cur_dst, 32'h2002);
        chk("R4", "no end yet", end_sts, 0);
    endtask

    task automatic t_end_stop();
        cfg_eclr = 1'b1; tc_out_en = 1'b1; ch_ie = 1'b1; com_ie = 1'b1;
        unit(2'd3);
        chk("R4", "cnt zero", cur_cnt, 0);
        chk("R4", "sts set", end_sts, 1);
        chk("R5", "irq", irq, 1);
        chk("R6", "tc low", tc_n, 0);
        chk("R7", "en cleared", chan_en, 0);
        chk("R8", "src last adv", cur_src, 32'h100A);
        chk("R8", "dst last adv", cur_dst, 32'h2006);
        tick();
        chk("R6", "tc one cycle", tc_n, 1);
        chk("R4", "sts sticky", end_sts, 1);
        unit(2'd0);
        chk("R9", "cnt off", cur_cnt, 0);
        chk("R9", "src off", cur_src, 32'h100A);
    endtask

    task automatic t_irq_clr();
        ch_ie = 1'b0; #1;
        chk("R5", "ch_ie off", irq, 0);
        ch_ie = 1'b1; com_ie = 1'b0; #1;
        chk("R5", "com_ie off", irq, 0);
        com_ie = 1'b1; #1;
        chk("R5", "both on", irq, 1);
        tick();
        sts_clr = 1'b1;
        tick();
        sts_clr = 1'b0;
        chk("R4", "cleared", end_sts, 0);
        chk("R5", "irq drop", irq, 0);
    endtask

    task automatic t_underflow();
        cfg_eclr = 1'b0; tc_out_en = 1'b0;
        do_start(32'h1000, 32'h2000, 24'd3);
        unit(2'd2);
        chk("R2", "clamp", cur_cnt, 0);
        chk("R4", "end", end_sts, 1);
        chk("R6", "tc masked", tc_n, 1);
        chk("R7", "en kept", chan_en, 1);
        unit(2'd2);
        chk("R9", "zero cnt src", cur_src, 32'h1004);
        chk("R9", "zero cnt", cur_cnt, 0);
        do_start(32'h1000, 32'h2000, 24'd0);
        unit(2'd0);
        chk("R9", "empty start", cur_dst, 32'h2000);
    endtask

    task automatic t_clr_vs_set();
        sts_clr = 1'b1;
        tick();
        chk("R4", "pre clear", end_sts, 0);
        do_start(32'h1000, 32'h2000, 24'd2);
        sts_clr = 1'b1;
        unit(2'd1);
        sts_clr = 1'b0;
        chk("R4", "set wins", end_sts, 1);
    endtask

    task automatic t_auto_reload();
        cfg_eclr = 1'b0; cfg_srld = 1'b1; cfg_drld = 1'b0; cfg_crld = 1'b1;
        tc_out_en = 1'b1; src_inc = 1'b1; dst_inc = 1'b1;
        do_start(32'h3000, 32'h4000, 24'd4);
        unit_sz = 2'd2; xfer_done = 1'b1;
        tick();
        chk("R8", "cnt reload", cur_cnt, 4);
        chk("R8", "src reload", cur_src, 32'h3000);
        chk("R8", "dst adv", cur_dst, 32'h4004);
        chk("R7", "en kept", chan_en, 1);
        chk("R6", "tc low", tc_n, 0);
        unit_sz = 2'd0;
        tick();
        xfer_done = 1'b0;
        chk("R9", "resume cnt", cur_cnt, 3);
        chk("R9", "resume src", cur_src, 32'h3001);
        chk("R6", "tc back", tc_n, 1);
        cfg_srld = 1'b0; cfg_drld = 1'b1; cfg_crld = 1'b0;
        do_start(32'h3000, 32'h4000, 24'd4);
        unit(2'd2);
        chk("R8", "src adv only", cur_src, 32'h3004);
        chk("R8", "dst reload", cur_dst, 32'h4000);
        chk("R8", "cnt no reload", cur_cnt, 0);
    endtask

    task automatic t_stop_reload();
        cfg_eclr = 1'b1; cfg_drld = 1'b0; cfg_crld = 1'b1;
        do_start(32'h5000, 32'h6000, 24'd4);
        rld_cnt = 24'd8;
        unit(2'd2);
        chk("R7", "stop", chan_en, 0);
        chk("R8", "cnt reload", cur_cnt, 8);
        unit(2'd2);
        chk("R9", "disabled cnt", cur_cnt, 8);
        chk("R9", "disabled src", cur_src, 32'h5004);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; start = 1'b0; xfer_done = 1'b0; unit_sz = 2'd0;
        src_inc = 1'b0; dst_inc = 1'b0; cfg_eclr = 1'b0; cfg_srld = 1'b0;
        cfg_drld = 1'b0; cfg_crld = 1'b0; tc_out_en = 1'b0; ch_ie = 1'b0;
        com_ie = 1'b0; sts_clr = 1'b0; rld_src = '0; rld_dst = '0; rld_cnt = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        tick();
        t_reset();
        t_start_step();
        t_end_stop();
        t_irq_clr();
        t_underflow();
        t_clr_vs_set();
        t_auto_reload();
        t_stop_reload();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule